// File: doc/BRIEF.md
# Boot Overlay and Bank Configuration Controller

This block sits on the write side of an 8-bit CPU bus, in front of the chip's address decoder. It watches every bus write and keeps a small set of configuration flags. From these flags and the current bus address it produces one region-select signal per memory target. The targets are the boot ROM, the interface ROM, the extended colour RAM, the I/O chips and ordinary RAM. It also drives a CPU speed flag.

After reset an 8KB boot ROM covers the top of the address space. It stays there until software writes any value to the CPU port at address $0001. Two bytes written in a row to the knock register at $D02F ($A5, then $96) put the video register set into its extended mode. Only in that mode do the two bank-control registers at $D030 and $D031 accept writes. Those registers can overlay the interface ROM, swap the upper I/O window for colour RAM, and select the fast CPU clock.

Top module: `memcfg_ctrl`

## Requirements
- R1: After reset the boot overlay is active, `ext_mode` is 0, both bank-control registers are all zero and `cpu_fast` is 0.
- R2: While the boot overlay is active, every address in $E000-$FFFF raises `sel_boot_rom`, whatever the bank-control bits hold.
- R3: A write of any value to $0001 switches the boot overlay off, and it stays off until reset. Afterwards $E000-$FFFF raises `sel_ram`.
- R4: A write of $A5 to $D02F followed by a write of $96 to $D02F sets `ext_mode` from the clock edge that takes the second write. Writes to other addresses between the two do not disturb the sequence.
- R5: Any other write to $D02F clears `ext_mode`. This covers a lone $96, and a non-$96 byte after $A5, which also disarms the sequence so that a later $96 does not unlock.
- R6: Bus cycles with `bus_we` low have no effect on the knock sequence, the boot overlay or the bank-control registers.
- R7: While `ext_mode` is 0, writes to $D030 and $D031 leave both registers unchanged.
- R8: With bit 5 of $D030 set, $C000-$CFFF raises `sel_iface_rom`. With it clear, that range raises `sel_ram`.
- R9: With bit 0 of $D030 set, $DC00-$DFFF raises `sel_ext_cram`, while $D000-$DBFF still raises `sel_io`.
- R10: `cpu_fast` follows bit 6 of $D031: 1 selects the fast clock and 0 the slow one.
- R11: For every address exactly one of the five select outputs is high. $D000-$DFFF defaults to `sel_io`, and every other address not claimed by an overlay raises `sel_ram`.
- R12: The bank-control bits keep their values when `ext_mode` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU bus address |
| bus_wdata | input | 8 | CPU write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| sel_boot_rom | output | 1 | Address maps to the boot ROM |
| sel_iface_rom | output | 1 | Address maps to the interface ROM |
| sel_ext_cram | output | 1 | Address maps to extended colour RAM |
| sel_io | output | 1 | Address maps to the I/O chips |
| sel_ram | output | 1 | Address maps to ordinary RAM |
| ext_mode | output | 1 | Extended video register mode is unlocked |
| cpu_fast | output | 1 | Fast CPU clock selected |

## Verification
Every flag is a register written at the clock edge that samples `bus_we`, so the effect of a write is visible one edge after it is presented. The select outputs are combinational from those flags and the address, so they are valid in the same cycle the address is driven. The bench drives each write on a falling edge and lets the next rising edge take it. It then drives a probe address on the following falling edge and samples the selects, `ext_mode` and `cpu_fast` a fraction of a nanosecond later, well clear of any rising edge.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

  typedef enum logic [0:0] {
    KNOCK_IDLE  = 1'b0,
    KNOCK_ARMED = 1'b1
  } knock_state_e;

  typedef struct packed {
    logic boot;
    logic iface;
    logic cram;
    logic io;
    logic ram;
  } region_sel_t;

  localparam int unsigned REGION_COUNT = $bits(region_sel_t);

endpackage

// File: rtl/memcfg_knock.sv
module memcfg_knock
  import memcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KNOCK_ADDR = 16'hD02F,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic              ext_mode
);

  knock_state_e state_q, state_d;
  logic         ext_d;
  logic         hit;

  assign hit = bus_we && (bus_addr == KNOCK_ADDR);

  always_comb begin
    state_d = state_q;
    ext_d   = ext_mode;
    if (hit) begin
      if (state_q == KNOCK_ARMED && bus_wdata == KEY_SECOND) begin
        ext_d   = 1'b1;
        state_d = KNOCK_IDLE;
      end else if (bus_wdata == KEY_FIRST) begin
        ext_d   = 1'b0;
        state_d = KNOCK_ARMED;
      end else begin
        ext_d   = 1'b0;
        state_d = KNOCK_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= KNOCK_IDLE;
      ext_mode <= 1'b0;
    end else begin
      state_q  <= state_d;
      ext_mode <= ext_d;
    end
  end

  // R4: unlocking needs the second key written to the knock register
  assert_unlock_key_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_mode) |-> $past(bus_we && bus_addr == KNOCK_ADDR && bus_wdata == KEY_SECOND));

  // R5: any other knock-register write leaves legacy mode
  assert_other_value_locks_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == KNOCK_ADDR && bus_wdata != KEY_SECOND) |=> !ext_mode);

  // R6: idle bus cycles leave the mode unchanged
  assert_read_no_effect_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(ext_mode));

endmodule

// File: rtl/memcfg_bankregs.sv
module memcfg_bankregs #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR   = 16'h0001,
  parameter logic [ADDR_W-1:0] CTRL_A_ADDR = 16'hD030,
  parameter logic [ADDR_W-1:0] CTRL_B_ADDR = 16'hD031
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              ext_mode,
  input  logic              din_cram,
  input  logic              din_iface,
  input  logic              din_fast,
  output logic              boot_on,
  output logic              cram_en,
  output logic              iface_en,
  output logic              cpu_fast
);

  logic wr_port, wr_a, wr_b;

  assign wr_port = bus_we && (bus_addr == PORT_ADDR);
  assign wr_a    = bus_we && ext_mode && (bus_addr == CTRL_A_ADDR);
  assign wr_b    = bus_we && ext_mode && (bus_addr == CTRL_B_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_on <= 1'b1;
    end else if (wr_port) begin
      boot_on <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cram_en  <= 1'b0;
      iface_en <= 1'b0;
    end else if (wr_a) begin
      cram_en  <= din_cram;
      iface_en <= din_iface;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_fast <= 1'b0;
    end else if (wr_b) begin
      cpu_fast <= din_fast;
    end
  end

  // R3: the overlay only drops on a CPU port write
  assert_boot_clear_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(boot_on) |-> $past(bus_we && bus_addr == PORT_ADDR));

  // R3: once off, the overlay stays off until reset
  assert_boot_stays_off_R3: assert property (@(posedge clk) disable iff (rst)
    !boot_on |=> !boot_on);

  // R7: locked registers ignore writes
  assert_locked_write_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !ext_mode && (bus_addr == CTRL_A_ADDR || bus_addr == CTRL_B_ADDR))
      |=> ($stable(cram_en) && $stable(iface_en) && $stable(cpu_fast)));

  // R12: leaving extended mode keeps the bank bits
  assert_bits_kept_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_mode) |-> ($stable(cram_en) && $stable(iface_en) && $stable(cpu_fast)));

endmodule

// File: rtl/memcfg_decode.sv
module memcfg_decode
  import memcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BOOT_LO  = 16'hE000,
  parameter logic [ADDR_W-1:0] BOOT_HI  = 16'hFFFF,
  parameter logic [ADDR_W-1:0] IFACE_LO = 16'hC000,
  parameter logic [ADDR_W-1:0] IFACE_HI = 16'hCFFF,
  parameter logic [ADDR_W-1:0] IO_LO    = 16'hD000,
  parameter logic [ADDR_W-1:0] IO_HI    = 16'hDFFF,
  parameter logic [ADDR_W-1:0] CRAM_LO  = 16'hDC00,
  parameter logic [ADDR_W-1:0] CRAM_HI  = 16'hDFFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              boot_on,
  input  logic              iface_en,
  input  logic              cram_en,
  output region_sel_t       sel
);

  logic in_boot, in_iface, in_io, in_cram;

  assign in_boot  = (addr >= BOOT_LO)  && (addr <= BOOT_HI);
  assign in_iface = (addr >= IFACE_LO) && (addr <= IFACE_HI);
  assign in_io    = (addr >= IO_LO)    && (addr <= IO_HI);
  assign in_cram  = (addr >= CRAM_LO)  && (addr <= CRAM_HI);

  always_comb begin
    sel = '0;
    if (boot_on && in_boot) begin
      sel.boot = 1'b1;
    end else if (iface_en && in_iface) begin
      sel.iface = 1'b1;
    end else if (cram_en && in_cram) begin
      sel.cram = 1'b1;
    end else if (in_io) begin
      sel.io = 1'b1;
    end else begin
      sel.ram = 1'b1;
    end
  end

endmodule

// File: rtl/memcfg_ctrl.sv
module memcfg_ctrl
  import memcfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CRAM_BIT  = 0,
  parameter int unsigned IFACE_BIT = 5,
  parameter int unsigned FAST_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic              sel_boot_rom,
  output logic              sel_iface_rom,
  output logic              sel_ext_cram,
  output logic              sel_io,
  output logic              sel_ram,
  output logic              ext_mode,
  output logic              cpu_fast
);

  logic        boot_on, cram_en, iface_en;
  region_sel_t sel;

  memcfg_knock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_knock (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .ext_mode(ext_mode)
  );

  memcfg_bankregs #(.ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .ext_mode(ext_mode),
    .din_cram(bus_wdata[CRAM_BIT]), .din_iface(bus_wdata[IFACE_BIT]),
    .din_fast(bus_wdata[FAST_BIT]),
    .boot_on(boot_on), .cram_en(cram_en), .iface_en(iface_en), .cpu_fast(cpu_fast)
  );

  memcfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .boot_on(boot_on), .iface_en(iface_en),
    .cram_en(cram_en), .sel(sel)
  );

  assign sel_boot_rom  = sel.boot;
  assign sel_iface_rom = sel.iface;
  assign sel_ext_cram  = sel.cram;
  assign sel_io        = sel.io;
  assign sel_ram       = sel.ram;

  // R11: exactly one target per address
  assert_one_region_R11: assert property (@(posedge clk) disable iff (rst)
    $countones({sel_boot_rom, sel_iface_rom, sel_ext_cram, sel_io, sel_ram}) == 1);

  // R2: the top window goes to the boot ROM while the overlay holds
  assert_boot_window_R2: assert property (@(posedge clk) disable iff (rst)
    (boot_on && bus_addr >= 16'hE000) |-> sel_boot_rom);

endmodule

// File: tb/tb_memcfg_ctrl.sv
module tb_memcfg_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic sel_boot_rom, sel_iface_rom, sel_ext_cram, sel_io, sel_ram, ext_mode, cpu_fast;

  int checks = 0;
  int failures = 0;

  // select vector: {boot, iface, cram, io, ram}
  localparam logic [4:0] S_BOOT = 5'b10000, S_IFACE = 5'b01000,
                         S_CRAM = 5'b00100, S_IO = 5'b00010, S_RAM = 5'b00001;

  always #2 clk = ~clk;

  memcfg_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .sel_boot_rom(sel_boot_rom), .sel_iface_rom(sel_iface_rom),
    .sel_ext_cram(sel_ext_cram), .sel_io(sel_io), .sel_ram(sel_ram),
    .ext_mode(ext_mode), .cpu_fast(cpu_fast)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle_at(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_wdata = 8'h96; bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic probe(input string tag, input logic [15:0] a, input logic [4:0] exp);
    bus_addr = a;
    #1;
    chk(tag, {27'd0, sel_boot_rom, sel_iface_rom, sel_ext_cram, sel_io, sel_ram}, {27'd0, exp});
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset();
    chk("R1 ext_mode", {31'd0, ext_mode}, 0);
    chk("R1 cpu_fast", {31'd0, cpu_fast}, 0);
    probe("R1 boot at E000", 16'hE000, S_BOOT);
    probe("R1 C000 ram", 16'hC000, S_RAM);
    probe("R1 DC00 io", 16'hDC00, S_IO);
  endtask

  task automatic t_boot_overlay;
    do_reset();
    probe("R2 FFFF boot", 16'hFFFF, S_BOOT);
    probe("R11 DFFF io", 16'hDFFF, S_IO);
    probe("R11 1234 ram", 16'h1234, S_RAM);
    probe("R11 D000 io", 16'hD000, S_IO);
    wr(16'h0002, 8'h00);
    probe("R3 other addr keeps boot", 16'hE000, S_BOOT);
    wr(16'h0001, 8'h37);
    probe("R3 E000 ram after port write", 16'hE000, S_RAM);
    probe("R3 FFFF ram after port write", 16'hFFFF, S_RAM);
    wr(16'h0001, 8'h00);
    probe("R3 stays off", 16'hF000, S_RAM);
  endtask

  task automatic t_knock;
    do_reset();
    wr(16'hD02F, 8'h96);
    chk("R5 lone second key", {31'd0, ext_mode}, 0);
    wr(16'hD02F, 8'hA5);
    wr(16'h0400, 8'h11);
    chk("R4 armed not yet unlocked", {31'd0, ext_mode}, 0);
    wr(16'hD02F, 8'h96);
    chk("R4 unlocked", {31'd0, ext_mode}, 1);
    wr(16'hD02F, 8'h00);
    chk("R5 other value locks", {31'd0, ext_mode}, 0);
    wr(16'hD02F, 8'hA5);
    wr(16'hD02F, 8'h12);
    wr(16'hD02F, 8'h96);
    chk("R5 broken sequence disarms", {31'd0, ext_mode}, 0);
    wr(16'hD02F, 8'hA5);
    idle_at(16'hD02F);
    idle_at(16'hD02F);
    wr(16'hD02F, 8'h96);
    chk("R6 reads leave sequence armed", {31'd0, ext_mode}, 1);
    idle_at(16'hD02F);
    chk("R6 read leaves mode", {31'd0, ext_mode}, 1);
  endtask

  task automatic t_bank_bits;
    do_reset();
    wr(16'h0001, 8'h00);
    wr(16'hD030, 8'h21);
    wr(16'hD031, 8'h40);
    probe("R7 locked D030", 16'hC000, S_RAM);
    chk("R7 locked D031", {31'd0, cpu_fast}, 0);
    wr(16'hD02F, 8'hA5);
    wr(16'hD02F, 8'h96);
    wr(16'hD030, 8'h20);
    probe("R8 iface at C000", 16'hC000, S_IFACE);
    probe("R8 iface at CFFF", 16'hCFFF, S_IFACE);
    probe("R9 cram off DC00 io", 16'hDC00, S_IO);
    wr(16'hD030, 8'h01);
    probe("R8 iface cleared", 16'hC800, S_RAM);
    probe("R9 cram at DC00", 16'hDC00, S_CRAM);
    probe("R9 cram at DFFF", 16'hDFFF, S_CRAM);
    probe("R9 DBFF io", 16'hDBFF, S_IO);
    wr(16'hD031, 8'h40);
    chk("R10 fast", {31'd0, cpu_fast}, 1);
    idle_at(16'hD031);
    chk("R6 read keeps fast", {31'd0, cpu_fast}, 1);
    wr(16'hD030, 8'h21);
    wr(16'hD02F, 8'h00);
    chk("R12 fast kept", {31'd0, cpu_fast}, 1);
    probe("R12 iface kept", 16'hC000, S_IFACE);
    probe("R12 cram kept", 16'hDD00, S_CRAM);
    wr(16'hD031, 8'h00);
    chk("R7 locked clear attempt", {31'd0, cpu_fast}, 1);
    wr(16'hD02F, 8'hA5);
    wr(16'hD02F, 8'h96);
    wr(16'hD031, 8'hBF);
    chk("R10 slow", {31'd0, cpu_fast}, 0);
  endtask

  task automatic t_boot_priority;
    do_reset();
    wr(16'hD02F, 8'hA5);
    wr(16'hD02F, 8'h96);
    wr(16'hD030, 8'h21);
    probe("R2 boot over bank bits", 16'hE000, S_BOOT);
    probe("R8 iface while boot on", 16'hC000, S_IFACE);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_boot_overlay();
    t_knock();
    t_bank_bits();
    t_boot_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule